// File: doc/BRIEF.md
# Serial Register Front End for a Four-Channel Converter Bank

This block is the serial slave port of a four-channel converter. A host drives chip select, serial clock and serial data. The block oversamples these pins with the system clock. It takes in 24-bit frames and decodes each frame as a read or a write to a bank of sixteen register addresses. The bank holds an identity word, a per-channel update-mode word, a control word, gain, trigger and broadcast words, and one data word per channel. Downstream converter logic receives the active code of every channel, plus a one-cycle strobe whenever a code changes.

The host reads a register in two frames. The first frame names the register. The second frame returns its contents on the serial output. A control bit picks the serial-clock edge on which the output bit changes. A second control bit turns the serial output into a 24-clock copy of the serial input. With that bit set, several devices can sit in one chain and all be written in a single chip-select window.

Each channel has its own update-mode bit. When that bit is clear, a new code takes effect as soon as the frame ends. When it is set, the new code waits for the shared load input. A static strap selects whether the channel codes come out of reset at zero or at mid-scale.

Top module: `dac_spi_regif`

## Requirements
- R1: A frame is sent MSB first as a read flag (1 = read), a 7-bit address and 16 data bits. SDI is taken on each falling SCLK edge while cs_n is low. Outside chaining, a frame takes effect only if cs_n rises after exactly 24 falling edges. Any other count leaves every register and output unchanged.
- R2: Only address bits [3:0] select a register; bits [6:4] are ignored. Address 0 is a no-op, 1 identity, 2 update-mode, 3 control, 4 gain, 5 trigger, 6 broadcast, 7 status. Channel n sits at 8+n, and 12 to 15 are unmapped.
- R3: After reset, the update-mode word is 0xFF00. Identity reads the DEV_ID parameter (default 0x1A40). Control, gain, trigger, broadcast, status and the held read word are 0x0000. Every channel code is 0x8000 when rst_mid is 1 and 0x0000 when it is 0.
- R4: A committed read frame holds the addressed register. During the next frame, SDO shifts out 8 zero bits, then that held value MSB first. Bits after the 24th are zero. Unmapped addresses read 0x0000, and a channel address reads the last value written to it.
- R5: With control bit 1 clear, SDO changes on rising SCLK edges, and the first bit appears at the first rising edge. With it set, SDO changes on falling edges, and the first bit appears once cs_n is low.
- R6: With control bit 0 set (chain mode), SDO repeats the SDI bit received 24 clocks earlier. A frame commits when its clock count is a nonzero multiple of 24, and only its last 24 bits act on this block.
- R7: In chain mode a read frame has no effect, and the held read word keeps its previous value.
- R8: Writes to the no-op, identity and status addresses, and to addresses 12 to 15, change no register.
- R9: A write to channel n while update-mode bit n is 0 changes that channel's code and pulses its strobe for one cycle. Both appear on the third clock edge after cs_n rises.
- R10: While update-mode bit n is 1, a write to channel n leaves its code unchanged. At the next clock edge on which load_all is high, every such pending channel takes its written value and pulses its strobe once.
- R11: Control bit 2 (error-check enable) is stored and read back, and has no effect on frame handling.
- R12: SDO is low while cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read-back or chain copy) |
| load_all | input | 1 | Applies all pending channel codes when high |
| rst_mid | input | 1 | Static strap: channel codes reset to mid-scale |
| dac_code | output | CHANNELS*16 | Active code of each channel, channel 0 in the low bits |
| dac_update | output | CHANNELS | One-cycle strobe per channel when its code changes |

## Verification
Every serial pin goes through a two-stage synchronizer and an edge register. So SDO changes, frame commits, new channel codes and their strobes all land on the third clock edge after the pin event. A load request acts on the first edge after it is sampled. The bench holds each SCLK phase for four clocks and samples SDO at the end of the phase, one clock after the latest possible change. It reads codes and strobe counts six clocks after cs_n rises, when every frame result is settled. A per-cycle monitor counts strobes, so an extra or doubled pulse shows up in the channel totals.

// File: rtl/dac_spi_pkg.sv
package dac_spi_pkg;

  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 7;
  localparam int FRAME_W = 1 + ADDR_W + DATA_W;

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } frame_t;

  typedef enum logic [3:0] {
    A_NOP   = 4'd0,
    A_IDENT = 4'd1,
    A_MODE  = 4'd2,
    A_CTRL  = 4'd3,
    A_GAIN  = 4'd4,
    A_TRIG  = 4'd5,
    A_BCAST = 4'd6,
    A_STAT  = 4'd7,
    A_CH0   = 4'd8
  } reg_addr_e;

  localparam int CTL_CHAIN  = 0;
  localparam int CTL_FALL   = 1;
  localparam int CTL_ERRCHK = 2;

  localparam logic [DATA_W-1:0] MODE_RST = 16'hFF00;

endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] ff_q;
  logic [STAGES-1:0] ff_n;

  generate
    if (STAGES == 1) begin : g_one
      assign ff_n = d;
    end else begin : g_many
      assign ff_n = {ff_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ff_q <= {STAGES{RST_VAL}};
    else        ff_q <= ff_n;
  end

  assign q = ff_q[STAGES-1];

endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import dac_spi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  input  logic              chain_en,
  input  logic              sdo_fall,
  input  logic [DATA_W-1:0] rd_word,
  output logic              frame_vld,
  output frame_t            frame,
  output logic              sdo
);

  localparam int               CNT_W = $clog2(FRAME_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(FRAME_W - 1);
  localparam int               PAD_W = FRAME_W - DATA_W;

  logic cs_s, sclk_s, sdi_s;

  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cs_sync (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sck_sync (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  bit_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sdi_sync (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

  logic               cs_d, sclk_d;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               one_q, one_n;
  logic               many_q, many_n;
  logic [FRAME_W-1:0] in_q, in_n;
  logic [FRAME_W-1:0] out_q, out_n;
  logic               sdo_q, sdo_n;
  logic               cs_fall, cs_rise, sck_fall, sck_rise, out_bit;

  // next-state
  always_comb begin
    cs_fall  = ~cs_s & cs_d;
    cs_rise  = cs_s & ~cs_d;
    sck_fall = ~cs_s & ~sclk_s & sclk_d;
    sck_rise = ~cs_s & sclk_s & ~sclk_d;
    out_bit  = chain_en ? in_q[FRAME_W-1] : out_q[FRAME_W-1];

    cnt_n  = cnt_q;
    one_n  = one_q;
    many_n = many_q;
    in_n   = in_q;
    out_n  = out_q;
    sdo_n  = sdo_q;

    if (cs_fall) begin
      cnt_n  = '0;
      one_n  = 1'b0;
      many_n = 1'b0;
      out_n  = {{PAD_W{1'b0}}, rd_word};
      sdo_n  = 1'b0;
    end else begin
      if (sck_fall) begin
        in_n  = {in_q[FRAME_W-2:0], sdi_s};
        out_n = {out_q[FRAME_W-2:0], 1'b0};
        if (cnt_q == LAST) begin
          cnt_n  = '0;
          one_n  = 1'b1;
          many_n = many_q | one_q;
        end else begin
          cnt_n = cnt_q + CNT_W'(1);
        end
      end
      if (sck_rise) sdo_n = out_bit;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_d   <= 1'b1;
      sclk_d <= 1'b0;
      cnt_q  <= '0;
      one_q  <= 1'b0;
      many_q <= 1'b0;
      in_q   <= '0;
      out_q  <= '0;
      sdo_q  <= 1'b0;
    end else begin
      cs_d   <= cs_s;
      sclk_d <= sclk_s;
      cnt_q  <= cnt_n;
      one_q  <= one_n;
      many_q <= many_n;
      in_q   <= in_n;
      out_q  <= out_n;
      sdo_q  <= sdo_n;
    end
  end

  assign frame_vld = cs_rise & one_q & (cnt_q == '0) & (chain_en | ~many_q);
  assign frame     = frame_t'(in_q);
  assign sdo       = ~cs_s & (sdo_fall ? out_bit : sdo_q);

endmodule

// File: rtl/dac_reg_bank.sv
module dac_reg_bank
  import dac_spi_pkg::*;
#(
  parameter int                CHANNELS = 4,
  parameter logic [DATA_W-1:0] DEV_ID   = 16'h1A40
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         frame_vld,
  input  frame_t                       frame,
  input  logic                         load_all,
  input  logic                         rst_mid,
  output logic [DATA_W-1:0]            rd_word,
  output logic                         chain_en,
  output logic                         sdo_fall,
  output logic [CHANNELS*DATA_W-1:0]   dac_code,
  output logic [CHANNELS-1:0]          dac_update
);

  logic [DATA_W-1:0] mode_q, mode_n, ctrl_q, ctrl_n, gain_q, gain_n;
  logic [DATA_W-1:0] trig_q, trig_n, bcast_q, bcast_n, hold_q, hold_n;
  logic [DATA_W-1:0] rd_mux, code_rst;
  logic [3:0]        addr4;
  logic              wr, rd;
  logic [CHANNELS-1:0][DATA_W-1:0] buf_bus;
  logic              unused_addr_hi;

  assign addr4          = frame.addr[3:0];
  assign unused_addr_hi = ^frame.addr[ADDR_W-1:4];
  assign code_rst       = {rst_mid, {(DATA_W-1){1'b0}}};
  assign wr             = frame_vld & ~frame.rd;
  assign rd             = frame_vld & frame.rd & ~ctrl_q[CTL_CHAIN];

  always_comb begin
    rd_mux = '0;
    case (addr4)
      A_IDENT: rd_mux = DEV_ID;
      A_MODE:  rd_mux = mode_q;
      A_CTRL:  rd_mux = ctrl_q;
      A_GAIN:  rd_mux = gain_q;
      A_TRIG:  rd_mux = trig_q;
      A_BCAST: rd_mux = bcast_q;
      default: begin
        for (int c = 0; c < CHANNELS; c++)
          if (addr4 == 4'(A_CH0 + c)) rd_mux = buf_bus[c];
      end
    endcase
  end

  // next-state of the shared words
  always_comb begin
    mode_n  = mode_q;
    ctrl_n  = ctrl_q;
    gain_n  = gain_q;
    trig_n  = trig_q;
    bcast_n = bcast_q;
    hold_n  = hold_q;
    if (wr) begin
      case (addr4)
        A_MODE:  mode_n  = frame.data;
        A_CTRL:  ctrl_n  = frame.data;
        A_GAIN:  gain_n  = frame.data;
        A_TRIG:  trig_n  = frame.data;
        A_BCAST: bcast_n = frame.data;
        default: ;
      endcase
    end
    if (rd) hold_n = rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_RST;
      ctrl_q  <= '0;
      gain_q  <= '0;
      trig_q  <= '0;
      bcast_q <= '0;
      hold_q  <= '0;
    end else begin
      mode_q  <= mode_n;
      ctrl_q  <= ctrl_n;
      gain_q  <= gain_n;
      trig_q  <= trig_n;
      bcast_q <= bcast_n;
      hold_q  <= hold_n;
    end
  end

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      logic [DATA_W-1:0] buf_q, buf_n, act_q, act_n;
      logic              pend_q, pend_n, upd_q, upd_n, hit;

      always_comb begin
        hit    = wr && (addr4 == 4'(A_CH0 + c));
        buf_n  = buf_q;
        act_n  = act_q;
        pend_n = pend_q;
        upd_n  = 1'b0;
        if (hit) begin
          buf_n = frame.data;
          if (mode_q[c]) begin
            pend_n = 1'b1;
          end else begin
            act_n = frame.data;
            upd_n = 1'b1;
          end
        end else if (load_all && pend_q) begin
          act_n  = buf_q;
          pend_n = 1'b0;
          upd_n  = 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          buf_q  <= code_rst;
          act_q  <= code_rst;
          pend_q <= 1'b0;
          upd_q  <= 1'b0;
        end else begin
          buf_q  <= buf_n;
          act_q  <= act_n;
          pend_q <= pend_n;
          upd_q  <= upd_n;
        end
      end

      assign buf_bus[c]                    = buf_q;
      assign dac_code[c*DATA_W +: DATA_W]  = act_q;
      assign dac_update[c]                 = upd_q;
    end
  endgenerate

  assign rd_word  = hold_q;
  assign chain_en = ctrl_q[CTL_CHAIN];
  assign sdo_fall = ctrl_q[CTL_FALL];

endmodule

// File: rtl/dac_spi_regif.sv
module dac_spi_regif
  import dac_spi_pkg::*;
#(
  parameter int                CHANNELS    = 4,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DATA_W-1:0] DEV_ID      = 16'h1A40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       cs_n,
  input  logic                       sclk,
  input  logic                       sdi,
  output logic                       sdo,
  input  logic                       load_all,
  input  logic                       rst_mid,
  output logic [CHANNELS*DATA_W-1:0] dac_code,
  output logic [CHANNELS-1:0]        dac_update
);

  logic              frame_vld;
  frame_t            frame;
  logic [DATA_W-1:0] rd_word;
  logic              chain_en, sdo_fall;

  spi_frame_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
    .chain_en(chain_en), .sdo_fall(sdo_fall), .rd_word(rd_word),
    .frame_vld(frame_vld), .frame(frame), .sdo(sdo));

  dac_reg_bank #(.CHANNELS(CHANNELS), .DEV_ID(DEV_ID)) u_bank (
    .clk(clk), .rst_n(rst_n), .frame_vld(frame_vld), .frame(frame),
    .load_all(load_all), .rst_mid(rst_mid), .rd_word(rd_word),
    .chain_en(chain_en), .sdo_fall(sdo_fall),
    .dac_code(dac_code), .dac_update(dac_update));

endmodule

// File: rtl/dac_spi_regif_chk.sv
module dac_spi_regif_chk #(
  parameter int CHANNELS = 4,
  parameter int DATA_W   = 16
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       cs_n,
  input logic                       sdo,
  input logic                       load_all,
  input logic                       frame_vld,
  input logic [CHANNELS*DATA_W-1:0] dac_code,
  input logic [CHANNELS-1:0]        dac_update
);

  logic [1:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_q <= 2'd0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  AST_SDO_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == 2'd3 && cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
      |-> !sdo); // R12

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_chk
      AST_STROBE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update[c] |=> !dac_update[c]); // R9

      AST_CODE_MOVES_WITH_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(dac_code[c*DATA_W +: DATA_W]) |-> dac_update[c]); // R10

      AST_STROBE_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        dac_update[c] |-> ($past(frame_vld) || $past(load_all))); // R9
    end
  endgenerate

endmodule

bind dac_spi_regif dac_spi_regif_chk #(.CHANNELS(CHANNELS), .DATA_W(16)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sdo(sdo), .load_all(load_all),
  .frame_vld(frame_vld), .dac_code(dac_code), .dac_update(dac_update));

// File: tb/tb_dac_spi_regif.sv
`timescale 1ns/1ps
module tb_dac_spi_regif;

  localparam int CH = 4;
  localparam logic [15:0] DEV = 16'h1A40;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi, load_all, rst_mid;
  logic sdo;
  logic [CH*16-1:0] dac_code;
  logic [CH-1:0]    dac_update;

  always #10 clk = ~clk;

  dac_spi_regif dut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi), .sdo(sdo),
    .load_all(load_all), .rst_mid(rst_mid), .dac_code(dac_code), .dac_update(dac_update));

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  // behavioural model
  logic [15:0] m_mode, m_ctrl, m_gain, m_trig, m_bcast, m_hold;
  logic [15:0] m_buf [CH];
  logic [15:0] m_act [CH];
  bit          m_pend[CH];
  int          exp_upd[CH];
  int          seen_upd[CH];

  always @(negedge clk) begin
    for (int c = 0; c < CH; c++) begin
      if (!rst_n) seen_upd[c] = 0;
      else if (dac_update[c]) seen_upd[c] = seen_upd[c] + 1;
    end
  end

  task automatic check(input string req, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] fr(input bit r, input logic [6:0] a, input logic [15:0] d);
    return {r, a, d};
  endfunction

  function automatic logic [15:0] m_read(input logic [3:0] a);
    case (a)
      4'd1: return DEV;
      4'd2: return m_mode;
      4'd3: return m_ctrl;
      4'd4: return m_gain;
      4'd5: return m_trig;
      4'd6: return m_bcast;
      4'd8, 4'd9, 4'd10, 4'd11: return m_buf[a - 4'd8];
      default: return 16'h0000;
    endcase
  endfunction

  task automatic m_apply(input logic [23:0] f);
    logic [3:0] a;
    a = f[19:16];
    if (f[23]) begin
      if (!m_ctrl[0]) m_hold = m_read(a);
    end else begin
      case (a)
        4'd2: m_mode  = f[15:0];
        4'd3: m_ctrl  = f[15:0];
        4'd4: m_gain  = f[15:0];
        4'd5: m_trig  = f[15:0];
        4'd6: m_bcast = f[15:0];
        4'd8, 4'd9, 4'd10, 4'd11: begin
          m_buf[a - 4'd8] = f[15:0];
          if (m_mode[a - 4'd8]) m_pend[a - 4'd8] = 1;
          else begin
            m_act[a - 4'd8] = f[15:0];
            exp_upd[a - 4'd8]++;
          end
        end
        default: ;
      endcase
    end
  endtask

  task automatic do_reset(input logic mid);
    rst_n = 0; cs_n = 1; sclk = 0; sdi = 0; load_all = 0; rst_mid = mid;
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_mode = 16'hFF00; m_ctrl = 0; m_gain = 0; m_trig = 0; m_bcast = 0; m_hold = 0;
    for (int c = 0; c < CH; c++) begin
      m_buf[c] = {mid, 15'b0}; m_act[c] = {mid, 15'b0}; m_pend[c] = 0; exp_upd[c] = 0;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic check_state(input string req);
    for (int c = 0; c < CH; c++) begin
      check(req, 72'(dac_code[c*16 +: 16]), 72'(m_act[c]));
      check(req, 72'(seen_upd[c]), 72'(exp_upd[c]));
    end
  endtask

  // n clocks of din[n-1:0], MSB first; SDO checked against the model
  task automatic xfer(input string req, input int n, input logic [71:0] din);
    logic [71:0] got, exp, mask;
    logic [23:0] outw;
    bit chain, fall, ok;
    chain = m_ctrl[0]; fall = m_ctrl[1];
    outw = {8'h00, m_hold};
    got = '0; exp = '0; mask = '0;
    for (int k = 0; k < n; k++) begin
      if (chain) begin
        if (k >= 24) begin mask[k] = 1; exp[k] = din[n-1-(k-24)]; end
      end else begin
        mask[k] = 1; exp[k] = (k < 24) ? outw[23-k] : 1'b0;
      end
    end
    @(negedge clk); cs_n = 0;
    repeat (4) @(negedge clk);
    for (int k = 0; k < n; k++) begin
      if (fall) got[k] = sdo;
      sclk = 1; sdi = din[n-1-k];
      repeat (4) @(negedge clk);
      if (!fall) got[k] = sdo;
      sclk = 0;
      repeat (4) @(negedge clk);
    end
    cs_n = 1;
    repeat (6) @(negedge clk);
    check(req, got & mask, exp & mask);
    ok = chain ? (n > 0 && n % 24 == 0) : (n == 24);
    if (ok) m_apply(din[23:0]);
  endtask

  task automatic load_pulse();
    @(negedge clk); load_all = 1;
    @(negedge clk); load_all = 0;
    for (int c = 0; c < CH; c++)
      if (m_pend[c]) begin m_act[c] = m_buf[c]; m_pend[c] = 0; exp_upd[c]++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    // R3: reset codes with both strap values
    do_reset(1'b0);
    check_state("R3 zero strap");
    do_reset(1'b1);
    check_state("R3 mid strap");
    check("R12 idle sdo", 72'(sdo), 72'(0));
    check("R9 no strobe at reset", 72'(dac_update), 72'(0));

    // R3/R4: read back reset values, each shown in the following frame
    xfer("R4 first", 24, 72'(fr(1, 7'h02, 16'h0)));
    xfer("R3 mode", 24, 72'(fr(1, 7'h01, 16'h0)));
    xfer("R3 ident", 24, 72'(fr(1, 7'h03, 16'h0)));
    xfer("R3 ctrl", 24, 72'(fr(1, 7'h04, 16'h0)));
    xfer("R3 gain", 24, 72'(fr(1, 7'h07, 16'h0)));
    xfer("R3 status", 24, 72'(fr(1, 7'h08, 16'h0)));
    xfer("R3 ch0", 24, 72'(fr(1, 7'h0D, 16'h0)));
    xfer("R4 unmapped", 24, 72'(fr(0, 7'h00, 16'h0)));

    // R9: immediate update
    xfer("R9 wr", 24, 72'(fr(0, 7'h09, 16'h1111)));
    check_state("R9 immediate");

    // R10: held update then load
    xfer("R10 mode", 24, 72'(fr(0, 7'h02, 16'hFF04)));
    xfer("R10 wr", 24, 72'(fr(0, 7'h0A, 16'h2222)));
    check_state("R10 held");
    load_pulse();
    check_state("R10 loaded");
    load_pulse();
    check_state("R10 second load no effect");

    // R8: ignored writes
    xfer("R8 a", 24, 72'(fr(0, 7'h01, 16'h5555)));
    xfer("R8 b", 24, 72'(fr(0, 7'h07, 16'h6666)));
    xfer("R8 c", 24, 72'(fr(0, 7'h00, 16'h7777)));
    xfer("R8 d", 24, 72'(fr(0, 7'h0C, 16'h8888)));
    xfer("R8 e", 24, 72'(fr(1, 7'h01, 16'h0)));
    xfer("R8 ident kept", 24, 72'(fr(1, 7'h07, 16'h0)));
    xfer("R8 status kept", 24, 72'(fr(1, 7'h0C, 16'h0)));
    xfer("R8 unmapped zero", 24, 72'(fr(0, 7'h00, 16'h0)));
    check_state("R8 codes kept");

    // R1: wrong lengths are dropped
    xfer("R1 short", 23, 72'(fr(0, 7'h08, 16'h3333) >> 1));
    xfer("R1 long", 25, {47'b0, fr(0, 7'h08, 16'h3333), 1'b0});
    xfer("R1 double", 48, {24'b0, fr(0, 7'h08, 16'h3434), fr(0, 7'h08, 16'h3535)});
    check_state("R1 discarded");
    // R2: upper address bits ignored
    xfer("R2 wr", 24, 72'(fr(0, 7'h78, 16'h4321)));
    check_state("R2 alias");

    // R5: falling-edge launch
    xfer("R5 cfg", 24, 72'(fr(0, 7'h03, 16'h0002)));
    xfer("R5 rd", 24, 72'(fr(1, 7'h09, 16'h0)));
    xfer("R5 fall sdo", 24, 72'(fr(1, 7'h03, 16'h0)));
    xfer("R5 back", 24, 72'(fr(0, 7'h03, 16'h0000)));

    // R6/R7/R11: chain mode
    xfer("R4 hold", 24, 72'(fr(1, 7'h06, 16'h0)));
    xfer("R6 enter", 24, 72'(fr(0, 7'h03, 16'h0001)));
    xfer("R6 pass", 48, {24'b0, fr(0, 7'h0B, 16'h1234), fr(0, 7'h09, 16'hBEEF)});
    check_state("R6 last word only");
    xfer("R7 read", 24, 72'(fr(1, 7'h02, 16'h0)));
    xfer("R6 exit", 24, 72'(fr(0, 7'h03, 16'h0004)));
    xfer("R7 hold kept", 24, 72'(fr(1, 7'h03, 16'h0)));
    xfer("R11 flag stored", 24, 72'(fr(0, 7'h00, 16'h0)));
    check_state("R11 codes");
    check("R12 idle sdo end", 72'(sdo), 72'(0));

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule